// File: doc/BRIEF.md
# ADC Window Limit Interrupt Monitor

This block sits behind an analog-to-digital converter and watches every finished conversion result. Each result arrives with a valid strobe, a channel number, an overflow marker and a 10-bit value. Four programmable comparison slots each watch one channel. A slot can flag results above its upper bound, below its lower bound, or both. The outcome from every slot feeds a single shared high flag and a single shared low flag.

Five sticky flags record events: conversion done, reference ready, high limit, low limit and overflow. Each flag has its own enable bit, and the enabled flags are combined into one registered interrupt line. Software programs the slots and the enables through a small word-wide register port. It clears flags by writing ones to them. Read data is registered and appears one cycle after the address.

Top module: `adc_limit_monitor`

## Requirements
- R1: Four slot configuration words live at addresses 2 to 5, one per slot. Each word holds the upper bound in bits [9:0], the lower bound in bits [19:10], the channel in bits [23:20], the high-watch enable in bit 28 and the low-watch enable in bit 29. Each word reads back exactly as it was written in those fields, with zeros in all other bits.
- R2: A valid result on a slot's channel sets the high flag (bit 2 of the flag word) when that slot's high-watch enable is 1 and the value is strictly greater than the slot's upper bound. A value equal to the bound does not set it.
- R3: A valid result on a slot's channel sets the low flag (bit 3) when that slot's low-watch enable is 1 and the value is strictly less than the slot's lower bound. A value equal to the bound does not set it.
- R4: A slot ignores results on any other channel, and ignores its high or low comparison while the matching watch enable is 0. When no slot qualifies, the high and low flags stay clear.
- R5: Every valid result sets the done flag (bit 0).
- R6: The reference-ready flag (bit 1) is set on each cycle that the reference-ready input is 1. It stays set after that input falls.
- R7: A valid result with the overflow input high sets the overflow flag (bit 4).
- R8: The interrupt output equals the OR, over all five flags, of flag AND enable, registered one cycle after the flag and enable values. The enable word is at address 1 and uses the same bit positions as the flags.
- R9: Flags are sticky. Writing a 1 to a bit of the flag word at address 0 clears that flag. If hardware sets a flag in the same cycle, the set wins.
- R10: After a synchronous reset, all flags, enables, bounds, channels and watch enables are 0, and the interrupt and read data are 0.
- R11: Read data shows the register selected by the address, as it stood before the clock edge that captures it, one cycle later. Unmapped addresses read as 0.
- R12: When several slots qualify on the same result, their outcomes are ORed into the shared high and low flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | Conversion result strobe |
| conv_data | input | 10 | Conversion value |
| conv_chan | input | 4 | Channel the result came from |
| conv_ovf | input | 1 | Result overflowed |
| ref_ready | input | 1 | Reference voltage is ready |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt |

## Verification
A result presented at clock edge N changes the flag word at that same edge. Read data sampled at N+1 shows the new flags, and the interrupt rises at N+1. Register writes follow the same timing: they take effect at their edge and show in read data one edge later. The bench drives stimulus on falling edges and advances a behavioural model on each rising edge. It compares the interrupt and the read data with the model on every falling edge. Directed reads are issued only after idle cycles, so each expected flag value is settled when it is checked.

// File: rtl/adc_mon_pkg.sv
package adc_mon_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int FL_DONE   = 0;
  localparam int FL_REF    = 1;
  localparam int FL_HI     = 2;
  localparam int FL_LO     = 3;
  localparam int FL_OVF    = 4;

  localparam int A_FLAGS   = 0;
  localparam int A_ENABLE  = 1;
  localparam int A_SLOT0   = 2;

  localparam int HIEN_BIT  = 28;
  localparam int LOEN_BIT  = 29;
endpackage

// File: rtl/limit_slot.sv
module limit_slot #(
  parameter int DATA_W   = 10,
  parameter int CHAN_W   = 4,
  parameter int REG_W    = 32,
  parameter int HIEN_POS = 28,
  parameter int LOEN_POS = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [CHAN_W-1:0] conv_chan,
  output logic              hit_hi,
  output logic              hit_lo,
  output logic [REG_W-1:0]  cfg_word
);
  localparam int LO_LSB = DATA_W;
  localparam int CH_LSB = 2 * DATA_W;

  logic [DATA_W-1:0] upper_q, lower_q;
  logic [CHAN_W-1:0] chan_q;
  logic              hien_q, loen_q;
  logic              chan_match;
  logic              unused_cfg;

  assign unused_cfg = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      lower_q <= '0;
      chan_q  <= '0;
      hien_q  <= 1'b0;
      loen_q  <= 1'b0;
    end else if (cfg_wr) begin
      upper_q <= wdata[DATA_W-1:0];
      lower_q <= wdata[LO_LSB +: DATA_W];
      chan_q  <= wdata[CH_LSB +: CHAN_W];
      hien_q  <= wdata[HIEN_POS];
      loen_q  <= wdata[LOEN_POS];
    end
  end

  always_comb begin
    chan_match = conv_valid && (conv_chan == chan_q);
    hit_hi     = chan_match && hien_q && (conv_data > upper_q);
    hit_lo     = chan_match && loen_q && (conv_data < lower_q);
  end

  always_comb begin
    cfg_word                     = '0;
    cfg_word[DATA_W-1:0]         = upper_q;
    cfg_word[LO_LSB +: DATA_W]   = lower_q;
    cfg_word[CH_LSB +: CHAN_W]   = chan_q;
    cfg_word[HIEN_POS]           = hien_q;
    cfg_word[LOEN_POS]           = loen_q;
  end
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  input  logic          en_wr,
  input  logic [NF-1:0] en_wdata,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] enables,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      enables <= '0;
      irq     <= 1'b0;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;
      if (en_wr) enables <= en_wdata;
      irq   <= |(flags & enables);
    end
  end
endmodule

// File: rtl/adc_limit_monitor.sv
module adc_limit_monitor
  import adc_mon_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int CHAN_W  = 4,
  parameter int N_SLOTS = 4,
  parameter int ADDR_W  = 3,
  parameter int REG_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_ovf,
  input  logic              ref_ready,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [N_SLOTS-1:0]   slot_hi, slot_lo;
  logic [REG_W-1:0]     slot_cfg [N_SLOTS];
  logic [NUM_FLAGS-1:0] set_vec, clr_vec;
  logic [NUM_FLAGS-1:0] flags_q, en_q;
  logic                 flags_sel, en_sel;
  logic [REG_W-1:0]     rd_mux;
  logic                 unused_wbits;

  assign unused_wbits = ^reg_wdata;
  assign flags_sel    = reg_addr == ADDR_W'(A_FLAGS);
  assign en_sel       = reg_addr == ADDR_W'(A_ENABLE);

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    limit_slot #(
      .DATA_W(DATA_W), .CHAN_W(CHAN_W), .REG_W(REG_W),
      .HIEN_POS(HIEN_BIT), .LOEN_POS(LOEN_BIT)
    ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .cfg_wr    (reg_wr && (reg_addr == ADDR_W'(A_SLOT0 + s))),
      .wdata     (reg_wdata),
      .conv_valid(conv_valid),
      .conv_data (conv_data),
      .conv_chan (conv_chan),
      .hit_hi    (slot_hi[s]),
      .hit_lo    (slot_lo[s]),
      .cfg_word  (slot_cfg[s])
    );
  end

  always_comb begin
    set_vec          = '0;
    set_vec[FL_DONE] = conv_valid;
    set_vec[FL_REF]  = ref_ready;
    set_vec[FL_HI]   = |slot_hi;
    set_vec[FL_LO]   = |slot_lo;
    set_vec[FL_OVF]  = conv_valid && conv_ovf;
    clr_vec          = (reg_wr && flags_sel) ? reg_wdata[NUM_FLAGS-1:0] : '0;
  end

  flag_bank #(.NF(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .en_wr   (reg_wr && en_sel),
    .en_wdata(reg_wdata[NUM_FLAGS-1:0]),
    .flags   (flags_q),
    .enables (en_q),
    .irq     (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (flags_sel) rd_mux[NUM_FLAGS-1:0] = flags_q;
    if (en_sel)    rd_mux[NUM_FLAGS-1:0] = en_q;
    for (int s = 0; s < N_SLOTS; s++)
      if (reg_addr == ADDR_W'(A_SLOT0 + s)) rd_mux = slot_cfg[s];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/adc_limit_monitor_chk.sv
module adc_limit_monitor_chk
  import adc_mon_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int REG_W  = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 conv_valid,
  input logic                 conv_ovf,
  input logic                 ref_ready,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [REG_W-1:0]     reg_wdata,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] enables,
  input logic                 irq
);
  logic clr_hi;
  assign clr_hi = reg_wr && (reg_addr == ADDR_W'(A_FLAGS)) && reg_wdata[FL_HI];

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(flags & enables))); // R8
  AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
    conv_valid |=> flags[FL_DONE]); // R5
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && conv_ovf) |=> flags[FL_OVF]); // R7
  AST_REF_SET: assert property (@(posedge clk) disable iff (rst)
    ref_ready |=> flags[FL_REF]); // R6
  AST_HI_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flags[FL_HI] && !clr_hi) |=> flags[FL_HI]); // R9
  AST_HI_NEEDS_CONV: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[FL_HI]) |-> $past(conv_valid)); // R4
  AST_LO_NEEDS_CONV: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[FL_LO]) |-> $past(conv_valid)); // R4
endmodule

bind adc_limit_monitor adc_limit_monitor_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_ovf(conv_ovf),
  .ref_ready(ref_ready), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .flags(flags_q), .enables(en_q), .irq(irq)
);

// File: tb/tb_adc_limit_monitor.sv
module tb_adc_limit_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_valid = 1'b0;
  logic [9:0]  conv_data = '0;
  logic [3:0]  conv_chan = '0;
  logic        conv_ovf = 1'b0;
  logic        ref_ready = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adc_limit_monitor dut (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
    .conv_chan(conv_chan), .conv_ovf(conv_ovf), .ref_ready(ref_ready),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [4:0]  m_flags, m_en;
  logic [9:0]  m_up [4];
  logic [9:0]  m_low [4];
  logic [3:0]  m_ch [4];
  logic        m_hie [4];
  logic        m_loe [4];
  logic        m_irq;
  logic [31:0] m_rdata;
  logic [4:0]  nxt;
  logic [31:0] rd_val;

  always @(posedge clk) begin
    if (rst) begin
      m_flags <= '0; m_en <= '0; m_irq <= 1'b0; m_rdata <= '0;
      for (int k = 0; k < 4; k++) begin
        m_up[k] <= '0; m_low[k] <= '0; m_ch[k] <= '0; m_hie[k] <= 1'b0; m_loe[k] <= 1'b0;
      end
    end else begin
      nxt = m_flags;
      if (reg_wr && reg_addr == 3'd0) nxt = nxt & ~reg_wdata[4:0];
      if (conv_valid) nxt[0] = 1'b1;
      if (ref_ready) nxt[1] = 1'b1;
      if (conv_valid && conv_ovf) nxt[4] = 1'b1;
      for (int k = 0; k < 4; k++) begin
        if (conv_valid && conv_chan == m_ch[k]) begin
          if (m_hie[k] && conv_data > m_up[k]) nxt[2] = 1'b1;
          if (m_loe[k] && conv_data < m_low[k]) nxt[3] = 1'b1;
        end
      end
      rd_val = '0;
      if (reg_addr == 3'd0) rd_val[4:0] = m_flags;
      else if (reg_addr == 3'd1) rd_val[4:0] = m_en;
      else if (reg_addr >= 3'd2 && reg_addr <= 3'd5) begin
        rd_val[9:0]   = m_up[reg_addr-2];
        rd_val[19:10] = m_low[reg_addr-2];
        rd_val[23:20] = m_ch[reg_addr-2];
        rd_val[28]    = m_hie[reg_addr-2];
        rd_val[29]    = m_loe[reg_addr-2];
      end
      m_rdata <= rd_val;
      m_irq   <= |(m_flags & m_en);
      m_flags <= nxt;
      if (reg_wr && reg_addr == 3'd1) m_en <= reg_wdata[4:0];
      if (reg_wr && reg_addr >= 3'd2 && reg_addr <= 3'd5) begin
        m_up[reg_addr-2]  <= reg_wdata[9:0];
        m_low[reg_addr-2] <= reg_wdata[19:10];
        m_ch[reg_addr-2]  <= reg_wdata[23:20];
        m_hie[reg_addr-2] <= reg_wdata[28];
        m_loe[reg_addr-2] <= reg_wdata[29];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R8 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      check("R11 rdata vs model", reg_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic conv(input logic [3:0] ch, input logic [9:0] v, input logic ov);
    @(negedge clk); conv_valid = 1'b1; conv_chan = ch; conv_data = v; conv_ovf = ov;
    @(negedge clk); conv_valid = 1'b0; conv_ovf = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk); reg_addr = a;
    @(negedge clk); check(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [31:0] slot_word(input int up, input int lo, input int ch,
                                            input bit he, input bit le);
    return (32'(le) << 29) | (32'(he) << 28) | (32'(ch) << 20) | (32'(lo) << 10) | 32'(up);
  endfunction

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 irq after reset", {31'd0, irq}, 32'd0);
    rd(3'd0, "R10 flags after reset", 32'd0);
    rd(3'd3, "R10 slot after reset", 32'd0);

    wr(3'd1, 32'h4);
    wr(3'd2, slot_word(500, 100, 3, 1, 1));
    wr(3'd3, slot_word(800, 200, 5, 1, 0));
    wr(3'd4, slot_word(600, 0, 3, 1, 0));
    wr(3'd5, slot_word(0, 1023, 3, 0, 0));
    rd(3'd2, "R1 slot0 readback", slot_word(500, 100, 3, 1, 1));
    rd(3'd5, "R1 slot3 readback", slot_word(0, 1023, 3, 0, 0));
    rd(3'd6, "R11 unmapped reads 0", 32'd0);

    conv(4'd3, 10'd500, 1'b0);
    rd(3'd0, "R2 equal to upper bound, R5 done", 32'h01);
    check("R8 irq off with done masked", {31'd0, irq}, 32'd0);

    conv(4'd3, 10'd501, 1'b0);
    @(negedge clk);
    check("R8 irq after high flag", {31'd0, irq}, 32'd1);
    rd(3'd0, "R2 above upper bound", 32'h05);

    wr(3'd0, 32'h05);
    rd(3'd0, "R9 write one clears", 32'h00);
    check("R8 irq drops after clear", {31'd0, irq}, 32'd0);

    conv(4'd7, 10'd1000, 1'b0);
    rd(3'd0, "R4 unwatched channel", 32'h01);
    conv(4'd3, 10'd300, 1'b0);
    rd(3'd0, "R4 disabled slot ignored", 32'h01);

    conv(4'd3, 10'd700, 1'b0);
    rd(3'd0, "R12 two slots fire", 32'h05);
    wr(3'd0, 32'h1F);

    conv(4'd3, 10'd100, 1'b0);
    rd(3'd0, "R3 equal to lower bound", 32'h01);
    conv(4'd3, 10'd99, 1'b0);
    rd(3'd0, "R3 below lower bound", 32'h09);

    wr(3'd0, 32'h1F);
    conv(4'd5, 10'd50, 1'b0);
    rd(3'd0, "R4 low watch disabled", 32'h01);

    wr(3'd0, 32'h1F);
    conv(4'd9, 10'd0, 1'b1);
    rd(3'd0, "R7 overflow flag", 32'h11);

    wr(3'd0, 32'h1F);
    @(negedge clk); ref_ready = 1'b1;
    @(negedge clk); ref_ready = 1'b0;
    rd(3'd0, "R6 reference ready", 32'h02);
    repeat (5) @(negedge clk);
    rd(3'd0, "R9 flag stays set", 32'h02);

    @(negedge clk);
    conv_valid = 1'b1; conv_chan = 4'd9; conv_data = 10'd0;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h1F;
    @(negedge clk);
    conv_valid = 1'b0; reg_wr = 1'b0;
    rd(3'd0, "R9 set wins over clear", 32'h01);

    rd(3'd1, "R8 enable readback", 32'h04);
    wr(3'd1, 32'h01);
    @(negedge clk);
    check("R8 irq from done enable", {31'd0, irq}, 32'd1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule